// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of an addressable RF step attenuator. It takes one programming request at a time and converts it into a 16-bit serial frame on three wires: a shift clock, a data line and a latch strobe. Each request carries a 7-bit attenuation code and a 3-bit device address. The code is in quarter-dB units, so the code equals four times the dB value.

The frame sends the attenuation byte first, least significant bit first. Bit 7 of that byte is always zero. The address byte follows, also LSB first. Its low three bits carry the target address and its upper five bits are driven as zeros.

Every interval on the wires is a whole number of system-clock cycles set by a parameter. These intervals are the shift-clock high and low times, the gap from the final clock to the strobe, the strobe width, and the rest period before the next request. At elaboration the block compares each interval with the minimum time the attenuator needs, using the stated system-clock period. If any interval is too short, elaboration stops with an error.

Top module: `atten_ser_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `ser_clk`, `ser_data` and `ser_latch` are 0. A reset in the middle of a frame abandons that frame.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 from the next cycle on. While it is 0, `req_valid`, `req_code` and `req_addr` have no effect on the frame being sent.
- R3: Each frame has exactly 16 rising edges of `ser_clk`. The bits sampled at those edges are, in order: code bits 0 to 6, then a 0, then address bits 0 to 2, then five 0s.
- R4: Within a frame, each high phase of `ser_clk` lasts exactly SCK_HI_CYC cycles. Each low phase between two rising edges lasts exactly SCK_LO_CYC cycles.
- R5: `ser_data` does not change while `ser_clk` is high. At every rising edge it has been stable for at least SCK_LO_CYC cycles.
- R6: `ser_latch` stays 0 until all 16 bits are shifted. It rises exactly SCK_HI_CYC+LE_SU_CYC cycles after the last rising edge, stays high for exactly LE_PW_CYC cycles, and is never high together with `ser_clk`.
- R7: `req_ready` returns to 1 exactly IDLE_CYC cycles after `ser_latch` falls. A request waiting at that point is taken at the very next edge, so `req_ready` is high for a single cycle.
- R8: A code of 73 (18.25 dB) sent to address 3 produces the serial stream 1,0,0,1,0,0,1,0 followed by 1,1,0,0,0,0,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Programming request present |
| req_code | input | CODE_W | Attenuation code in quarter-dB units |
| req_addr | input | ADDR_W | Target device address |
| req_ready | output | 1 | Block can accept a request |
| ser_clk | output | 1 | Serial shift clock |
| ser_data | output | 1 | Serial data, sampled on rising `ser_clk` |
| ser_latch | output | 1 | Latch strobe that transfers the frame |

## Verification
Two events can land in the same cycle: the end of the rest gap, when `req_ready` rises, and the acceptance of the next request. The bench provokes this by keeping `req_valid` high across the whole frame, with the second request's fields already on the inputs. It then checks two things. First, the first frame's bits are correct at the one cycle where ready is high. Second, the second frame is taken at the next edge and comes out correct. The bench also changes the request fields while the block is busy, and requires the frame in flight to stay unchanged.

// File: rtl/atten_pkg.sv
// Package: shared types for the serial attenuator programming master.
// Assumes one frame is two bytes long, shifted least significant bit first.
package atten_pkg;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;

    // Sequencer phases; the outputs are decoded from these.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOW   = 3'd1,
        PH_HIGH  = 3'd2,
        PH_LESU  = 3'd3,
        PH_LATCH = 3'd4,
        PH_GAP   = 3'd5
    } phase_e;
endpackage

// File: rtl/atten_frame_pack.sv
// Module: atten_frame_pack
// Builds the 16-bit frame from a request. The low byte holds the code with
// every bit above the code width forced to zero. The high byte holds the
// address with every bit above the address width forced to zero.
// Assumes CODE_W < BYTE_W and ADDR_W <= BYTE_W. Purely combinational.
module atten_frame_pack
    import atten_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int ADDR_W = 3
) (
    input  logic [CODE_W-1:0]  code_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [FRAME_W-1:0] frame_o
);
    // One generated slice per bit of each byte.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i < CODE_W) begin : g_code
            assign frame_o[i] = code_i[i];
        end else begin : g_code_pad
            assign frame_o[i] = 1'b0;
        end
        if (i < ADDR_W) begin : g_addr
            assign frame_o[BYTE_W+i] = addr_i[i];
        end else begin : g_addr_pad
            assign frame_o[BYTE_W+i] = 1'b0;
        end
    end
endmodule

// File: rtl/atten_phase_timer.sv
// Module: atten_phase_timer
// Down-counter that times one sequencer phase. Loading N-1 makes the phase
// last N cycles. expired_o is high on the phase's final cycle.
// Assumes the controller reloads only when the timer has expired.
module atten_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on a phase change, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4: a phase is never cut short by a reload before it has run out.
    reload_when_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> expired_o);
endmodule

// File: rtl/atten_shift_out.sv
// Module: atten_shift_out
// Holds the frame and presents its current bit on sdo_o. Each shift pulse
// moves to the next bit. last_o marks the final bit of the frame.
// Assumes shift pulses come only while bits remain.
module atten_shift_out
    import atten_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift_i,
    output logic               sdo_o,
    output logic               last_o
);
    localparam int LEFT_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh_q;
    logic [LEFT_W-1:0]  left_q;

    // Capture a new frame, or move one bit toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sh_q   <= frame_i;
            left_q <= LEFT_W'(FRAME_W);
        end else if (shift_i) begin
            sh_q   <= {1'b0, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
        end
    end

    assign sdo_o  = sh_q[0];
    assign last_o = (left_q == LEFT_W'(1));

    // R3: the controller never shifts past the end of the frame.
    no_overshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> (left_q > LEFT_W'(1)));
endmodule

// File: rtl/atten_seq_ctrl.sv
// Module: atten_seq_ctrl
// Phase sequencer. It accepts a request, runs a low and a high clock phase
// for every bit, waits the clock-to-latch setup, pulses the latch, and then
// waits the rest gap before going idle.
// Assumes every cycle count is at least 1.
module atten_seq_ctrl
    import atten_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int SCK_HI_CYC = 12,
    parameter int SCK_LO_CYC = 13,
    parameter int LE_SU_CYC  = 3,
    parameter int LE_PW_CYC  = 8,
    parameter int IDLE_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             expired_i,
    input  logic             last_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             sh_load_o,
    output logic             sh_shift_o,
    output phase_e           phase_o
);
    localparam logic [CNT_W-1:0] HI_LD = CNT_W'(SCK_HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LD = CNT_W'(SCK_LO_CYC - 1);
    localparam logic [CNT_W-1:0] SU_LD = CNT_W'(LE_SU_CYC - 1);
    localparam logic [CNT_W-1:0] PW_LD = CNT_W'(LE_PW_CYC - 1);
    localparam logic [CNT_W-1:0] GP_LD = CNT_W'(IDLE_CYC - 1);

    phase_e ph_q, ph_d;

    // Next phase, plus the timer and shifter controls for the change.
    always_comb begin
        ph_d       = ph_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        sh_load_o  = 1'b0;
        sh_shift_o = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (req_valid_i) begin
                ph_d = PH_LOW; tmr_load_o = 1'b1; tmr_val_o = LO_LD; sh_load_o = 1'b1;
            end
            PH_LOW: if (expired_i) begin
                ph_d = PH_HIGH; tmr_load_o = 1'b1; tmr_val_o = HI_LD;
            end
            PH_HIGH: if (expired_i) begin
                tmr_load_o = 1'b1;
                if (last_i) begin
                    ph_d = PH_LESU; tmr_val_o = SU_LD;
                end else begin
                    ph_d = PH_LOW; tmr_val_o = LO_LD; sh_shift_o = 1'b1;
                end
            end
            PH_LESU: if (expired_i) begin
                ph_d = PH_LATCH; tmr_load_o = 1'b1; tmr_val_o = PW_LD;
            end
            PH_LATCH: if (expired_i) begin
                ph_d = PH_GAP; tmr_load_o = 1'b1; tmr_val_o = GP_LD;
            end
            PH_GAP: if (expired_i) begin
                ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    assign phase_o = ph_q;

    // R2: an accepted request leaves the idle phase on the next cycle.
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE && req_valid_i) |=> (ph_q == PH_LOW));

    // R6: the latch phase is entered only from the clock-to-latch setup phase.
    latch_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LATCH && $past(ph_q) != PH_LATCH) |-> ($past(ph_q) == PH_LESU));
endmodule

// File: rtl/atten_ser_master.sv
// Module: atten_ser_master (top)
// Serial programming master for an addressable step attenuator. It takes
// code and address through a valid/ready handshake and drives the serial
// clock, data and latch with cycle-counted minimum timings.
// Assumes CLK_PS is the true system-clock period. Elaboration fails if any
// programmed interval is shorter than the attenuator's minimum.
module atten_ser_master
    import atten_pkg::*;
#(
    parameter int CODE_W     = 7,
    parameter int ADDR_W     = 3,
    parameter int CLK_PS     = 4000,
    parameter int SCK_HI_CYC = 12,
    parameter int SCK_LO_CYC = 13,
    parameter int LE_SU_CYC  = 3,
    parameter int LE_PW_CYC  = 8,
    parameter int IDLE_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch
);
    localparam int MIN_HI_PS   = 30000;
    localparam int MIN_LO_PS   = 30000;
    localparam int MIN_PER_PS  = 100000;
    localparam int MIN_SU_PS   = 10000;
    localparam int MIN_HOLD_PS = 10000;
    localparam int MIN_LESU_PS = 10000;
    localparam int MIN_LEPW_PS = 30000;
    localparam int CNT_W = $clog2(SCK_HI_CYC + SCK_LO_CYC + LE_SU_CYC + LE_PW_CYC + IDLE_CYC + 1);

    // Elaboration-time timing and shape checks.
    if (SCK_HI_CYC * CLK_PS < MIN_HI_PS || SCK_HI_CYC * CLK_PS < MIN_HOLD_PS) begin : g_bad_hi
        $error("serial clock high time or data hold too short");
    end
    if (SCK_LO_CYC * CLK_PS < MIN_LO_PS || SCK_LO_CYC * CLK_PS < MIN_SU_PS) begin : g_bad_lo
        $error("serial clock low time or data setup too short");
    end
    if ((SCK_HI_CYC + SCK_LO_CYC) * CLK_PS < MIN_PER_PS) begin : g_bad_per
        $error("serial clock faster than allowed");
    end
    if (LE_SU_CYC < 1 || (SCK_HI_CYC + LE_SU_CYC) * CLK_PS < MIN_LESU_PS) begin : g_bad_lesu
        $error("clock-to-latch setup too short");
    end
    if (LE_PW_CYC * CLK_PS < MIN_LEPW_PS) begin : g_bad_lepw
        $error("latch pulse too narrow");
    end
    if (IDLE_CYC < 1 || CODE_W >= BYTE_W || ADDR_W > BYTE_W) begin : g_bad_shape
        $error("illegal idle gap or field width");
    end

    logic [FRAME_W-1:0] frame;
    logic               tmr_load, expired, sh_load, sh_shift, last_bit;
    logic [CNT_W-1:0]   tmr_val;
    phase_e             phase;

    atten_frame_pack #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_pack (
        .code_i (req_code),
        .addr_i (req_addr),
        .frame_o(frame)
    );

    atten_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (expired)
    );

    atten_shift_out u_sh (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .frame_i(frame),
        .shift_i(sh_shift),
        .sdo_o  (ser_data),
        .last_o (last_bit)
    );

    atten_seq_ctrl #(
        .CNT_W(CNT_W), .SCK_HI_CYC(SCK_HI_CYC), .SCK_LO_CYC(SCK_LO_CYC),
        .LE_SU_CYC(LE_SU_CYC), .LE_PW_CYC(LE_PW_CYC), .IDLE_CYC(IDLE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid),
        .expired_i  (expired),
        .last_i     (last_bit),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .sh_load_o  (sh_load),
        .sh_shift_o (sh_shift),
        .phase_o    (phase)
    );

    // Wire outputs are decoded from the registered phase only.
    assign req_ready = (phase == PH_IDLE);
    assign ser_clk   = (phase == PH_HIGH);
    assign ser_latch = (phase == PH_LATCH);

    // R2: a handshake drops ready on the next cycle.
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: data holds still through every clock-high cycle.
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R6: latch and shift clock are never high together.
    latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_latch && ser_clk));

    // R7: the latch falling never coincides with ready.
    gap_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_latch) |-> !req_ready);

    // R1: when idle, the wires are quiet.
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ser_clk && !ser_latch));
endmodule

// File: tb/sim_atten_ser_master.sv
// Bench for atten_ser_master. Fixed-seed random requests and directed
// corner cases. A negedge monitor measures the serial timing and collects
// the frame bits.
module sim_atten_ser_master;
    localparam int HI = 12, LO = 13, SU = 3, PW = 8, GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [6:0] req_code = '0;
    logic [2:0] req_addr = '0;
    logic       req_ready, ser_clk, ser_data, ser_latch;

    int vecs = 0, errs = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    atten_ser_master #(
        .CODE_W(7), .ADDR_W(3), .CLK_PS(4000), .SCK_HI_CYC(HI),
        .SCK_LO_CYC(LO), .LE_SU_CYC(SU), .LE_PW_CYC(PW), .IDLE_CYC(GAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_addr(req_addr), .req_ready(req_ready), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_latch(ser_latch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_frame(input logic [6:0] c, input logic [2:0] a);
        return {5'b00000, a, 1'b0, c};
    endfunction

    // Monitor state.
    logic [15:0] got = '0;
    int   nbits = 0, run = 0, since_sdo = 0, since_rise = 0, lerun = 0, gapcnt = 0;
    bit   gap_on = 1'b0;
    logic p_sck = 0, p_le = 0, p_rdy = 1, p_sdo = 0;

    // Timing and data monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            nbits = 0; run = 0; since_sdo = 0; since_rise = 0; lerun = 0;
            gapcnt = 0; gap_on = 0;
        end else begin
            if (p_rdy && !req_ready) begin got = '0; nbits = 0; end
            since_sdo = (ser_data != p_sdo) ? 0 : since_sdo + 1;
            if (ser_clk && p_sck && ser_data != p_sdo)
                chk(0, "R5 data moved while clock high", ser_data, p_sdo);
            since_rise++;
            if (ser_clk != p_sck) begin
                if (ser_clk) begin
                    chk(since_sdo >= LO, "R5 setup before rise", since_sdo, LO);
                    if (nbits > 0) chk(run == LO, "R4 low phase", run, LO);
                    if (nbits < 16) got[nbits] = ser_data;
                    nbits++;
                    since_rise = 0;
                end else begin
                    chk(run == HI, "R4 high phase", run, HI);
                end
                run = 1;
            end else run++;
            if (ser_latch && !p_le) begin
                chk(nbits == 16, "R6 latch after all bits", nbits, 16);
                chk(since_rise == HI + SU, "R6 last rise to latch", since_rise, HI + SU);
                lerun = 1;
            end else if (ser_latch) lerun++;
            if (!ser_latch && p_le) begin
                chk(lerun == PW, "R6 latch width", lerun, PW);
                gap_on = 1; gapcnt = 0;
            end
            if (gap_on) begin
                if (req_ready) begin
                    chk(gapcnt == GAP, "R7 rest gap", gapcnt, GAP);
                    gap_on = 0;
                end else gapcnt++;
            end
        end
        p_sck = ser_clk; p_le = ser_latch; p_rdy = req_ready; p_sdo = ser_data;
    end

    // Send one request. Optionally disturb the inputs while the block is busy.
    task automatic send(input logic [6:0] c, input logic [2:0] a, input bit disturb, input string tag);
        logic [15:0] e;
        e = exp_frame(c, a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_code = c; req_addr = a;
        @(negedge clk);
        chk(req_ready == 0, "R2 ready drops", req_ready, 0);
        if (disturb) begin
            req_code = ~c; req_addr = ~a;
            repeat (60) @(negedge clk);
            req_code = c ^ 7'h55;
            repeat (60) @(negedge clk);
        end
        req_valid = 0;
        while (!req_ready) @(negedge clk);
        chk(got == e, {tag, " frame content"}, got, e);
        chk(nbits == 16, "R3 bit count", nbits, 16);
    endtask

    initial begin
        logic [15:0] e;
        void'($urandom(32'd20240611));
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
        chk({ser_clk, ser_data, ser_latch} == 3'b000, "R1 wires in reset", {ser_clk, ser_data, ser_latch}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && !ser_clk && !ser_latch && !ser_data, "R1 idle after reset", req_ready, 1);

        // R8 18.25 dB at address 3
        send(7'd73, 3'd3, 0, "R8");
        chk(got == 16'b0000_0011_0100_1001, "R8 exact stream", got, 16'h0349);
        // R3 corners: all ones, all zeros
        send(7'h7F, 3'h7, 0, "R3 all ones");
        send(7'h00, 3'h0, 0, "R3 all zeros");
        // R2 inputs changed while busy
        send(7'h2A, 3'h5, 1, "R2 busy ignore");

        // R7 back-to-back: valid held high, the next request waits at the rest-gap end
        e = exp_frame(7'h11, 3'h6);
        @(negedge clk);
        req_valid = 1; req_code = 7'h11; req_addr = 3'h6;
        @(negedge clk);
        req_code = 7'h6C; req_addr = 3'h1;
        while (!req_ready) @(negedge clk);
        chk(got == e, "R7 first of pair", got, e);
        @(negedge clk);
        chk(req_ready == 0, "R7 ready single cycle", req_ready, 0);
        req_valid = 0;
        e = exp_frame(7'h6C, 3'h1);
        while (!req_ready) @(negedge clk);
        chk(got == e, "R7 second of pair", got, e);

        // R3 random traffic
        for (int i = 0; i < 20; i++) begin
            send(7'($urandom), 3'($urandom), ($urandom % 4) == 0, "R3 random");
        end

        // R1 reset in the middle of a frame
        @(negedge clk);
        req_valid = 1; req_code = 7'h3C; req_addr = 3'h2;
        @(negedge clk);
        req_valid = 0;
        repeat (100) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(req_ready == 1 && !ser_clk && !ser_latch && !ser_data, "R1 mid-frame reset", req_ready, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        send(7'h05, 3'h4, 0, "R1 after abort");

        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vecs++; errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule